// File: doc/BRIEF.md
# Flat Panel Serial Pixel Transmitter

This block turns a parallel pixel (three colour components plus horizontal sync, vertical sync and data-enable) into 7-bit serial words, one word per data lane per frame. It also drives a forwarded clock lane, so a flat panel receiver can recover the word boundary. It runs on a single fast bit clock. One frame lasts seven bit clocks. The block requests pixels with a strobe, once per frame in single-channel mode and twice per frame in dual-channel mode. The serial rate is therefore 7 or 3.5 bit clocks per pixel.

Configuration is taken at run time. It selects 6- or 8-bit colour, one or two channels, a port enable, a mask that powers individual lanes, and a sequencing override. The override forces every used lane on or off regardless of the mask. Lanes that are unused, masked, overridden off or on a disabled port hold the serial output at 0 and raise a low-power flag.

Configuration is captured only at a frame boundary. A word that is partly shifted out is therefore never disturbed by a change.

Top module: `lvds_panel_ser`

## Requirements
- R1: While reset is held, every lane bit and the clock lane are 0, every low-power flag is 1 and the pixel request is 0.
- R2: A frame lasts 7 bit clocks, counted from reset release. In single-channel mode the pixel request is high only in the 7th cycle of each frame, and the bus is captured at the end of that cycle.
- R3: In dual-channel mode the pixel request is also high in the 4th cycle of each frame. The pixel captured there (even) goes to channel A (lanes 0-3). The pixel captured in the 7th cycle (odd) goes to channel B (lanes 4-7).
- R4: Each captured pixel forms the 28-bit word {R[7:2], G[7:2], B[7:2], HSYNC, VSYNC, DE, R[1:0], G[1:0], B[1:0], 0}. Channel lane k sends bits 27-7k down to 21-7k, MSB first, during the frame after the load.
- R5: With 6-bit colour only lanes 0-2 of a channel are used; with 8-bit colour lanes 0-3 are used. In single-channel mode lanes 4-7 are unused. Unused lanes are in low power.
- R6: A lane in low power drives 0. A used lane whose mask bit is 0 is in low power when no override is active.
- R7: When the port is disabled, every lane is in low power and the clock lane is 0.
- R8: While the override is enabled, every used lane is powered exactly when the override level is 1, whatever its mask bit.
- R9: On an enabled port the clock lane sends 1100011 in every frame, MSB first, aligned with the data words.
- R10: Configuration inputs are sampled only in the last cycle of a frame. They govern pixel requests in the next frame and lane output in the frame after that. Changes at any other cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pixR | input | 8 | Red component |
| pixG | input | 8 | Green component |
| pixB | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| depth8 | input | 1 | 1 = 8-bit colour, 0 = 6-bit |
| dual | input | 1 | 1 = dual channel |
| portEn | input | 1 | Port enable |
| laneEn | input | 8 | Per-lane power mask |
| seqOvrEn | input | 1 | Sequencing override active |
| seqOvrOn | input | 1 | Override level for used lanes |
| pixReq | output | 1 | Pixel bus is captured at the end of this cycle |
| laneBit | output | 8 | Serial data lanes |
| clkLane | output | 1 | Forwarded clock lane |
| laneLowPwr | output | 8 | Per-lane low-power flags |

## Verification
Pixel values change on every bit clock, so a word captured from the wrong cycle shows up as wrong serial bits. Separate runs use single and dual channel, at 6 and 8 bits each, to separate lane-count and channel-steering faults. A sparse mask, both override levels and a disabled port show whether the power precedence is right. A final run changes the configuration every few cycles, which exposes any sampling outside the frame boundary.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int LANE_BITS = 7;
  localparam int LANES_CH  = 4;
  localparam int NUM_CH    = 2;
  localparam int NUM_LANES = LANES_CH * NUM_CH;
  localparam int WORD_W    = LANE_BITS * LANES_CH;
  localparam int SLOT_W    = $clog2(LANE_BITS);

  typedef struct packed {
    logic       portEn;
    logic       dual;
    logic       depth8;
    logic       ovrEn;
    logic       ovrOn;
    logic [NUM_LANES-1:0] laneEn;
  } cfg_t;

  typedef struct packed {
    logic              captureEven;
    logic              loadWord;
    logic [SLOT_W-1:0] slot;
  } strobe_t;

  function automatic logic [WORD_W-1:0] packPixel(
    input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
    input logic hs, input logic vs, input logic dataEn);
    return {r[7:2], g[7:2], b[7:2], hs, vs, dataEn,
            r[1:0], g[1:0], b[1:0], 1'b0};
  endfunction
endpackage

// File: rtl/lvds_ser_ctrl.sv
module lvds_ser_ctrl
  import lvds_ser_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cfg_t    cfgIn,
  output cfg_t    cfgCap,
  output cfg_t    cfgOut,
  output strobe_t stb,
  output logic    pixReq
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LANE_BITS - 1);
  localparam logic [SLOT_W-1:0] MID  = SLOT_W'(LANE_BITS / 2);

  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      cfgCap <= '0;
      cfgOut <= '0;
    end else begin
      if (slot == LAST) begin
        slot   <= '0;
        cfgOut <= cfgCap;
        cfgCap <= cfgIn;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_comb begin
    stb.slot        = slot;
    stb.loadWord    = (slot == LAST);
    stb.captureEven = cfgCap.dual && (slot == MID);
    pixReq          = stb.loadWord || stb.captureEven;
  end
endmodule

// File: rtl/lvds_ser_datapath.sv
module lvds_ser_datapath
  import lvds_ser_pkg::*;
#(
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              stb,
  input  cfg_t                 cfgCap,
  input  cfg_t                 cfgOut,
  input  logic [WORD_W-1:0]    pixWord,
  output logic [NUM_LANES-1:0] laneBit,
  output logic [NUM_LANES-1:0] laneLowPwr,
  output logic                 clkLane
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LANE_BITS - 1);

  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] srcWord [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) holdWord <= '0;
    else if (stb.captureEven) holdWord <= pixWord;
  end

  always_comb begin
    srcWord[0] = cfgCap.dual ? holdWord : pixWord;
    srcWord[1] = cfgCap.dual ? pixWord : '0;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar k = 0; k < LANES_CH; k++) begin : g_lane
      localparam int IDX = ch * LANES_CH + k;
      localparam int TOP = WORD_W - 1 - k * LANE_BITS;
      logic [LANE_BITS-1:0] shReg;
      logic used, powered;

      always_ff @(posedge clk) begin
        if (rst) shReg <= '0;
        else if (stb.loadWord) shReg <= srcWord[ch][TOP -: LANE_BITS];
        else shReg <= {shReg[LANE_BITS-2:0], 1'b0};
      end

      always_comb begin
        used    = (k < LANES_CH - 1 || cfgOut.depth8) && (ch == 0 || cfgOut.dual);
        powered = cfgOut.portEn && used &&
                  (cfgOut.ovrEn ? cfgOut.ovrOn : cfgOut.laneEn[IDX]);
      end

      assign laneBit[IDX]    = powered & shReg[LANE_BITS-1];
      assign laneLowPwr[IDX] = ~powered;
    end
  end

  assign clkLane = cfgOut.portEn & CLK_PATTERN[LAST - stb.slot];
endmodule

// File: rtl/lvds_panel_ser.sv
module lvds_panel_ser
  import lvds_ser_pkg::*;
#(
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           pixR,
  input  logic [7:0]           pixG,
  input  logic [7:0]           pixB,
  input  logic                 hsync,
  input  logic                 vsync,
  input  logic                 de,
  input  logic                 depth8,
  input  logic                 dual,
  input  logic                 portEn,
  input  logic [NUM_LANES-1:0] laneEn,
  input  logic                 seqOvrEn,
  input  logic                 seqOvrOn,
  output logic                 pixReq,
  output logic [NUM_LANES-1:0] laneBit,
  output logic                 clkLane,
  output logic [NUM_LANES-1:0] laneLowPwr
);
  cfg_t cfgIn, cfgCap, cfgOut;
  strobe_t stb;
  logic [WORD_W-1:0] pixWord;

  assign cfgIn   = '{portEn: portEn, dual: dual, depth8: depth8,
                     ovrEn: seqOvrEn, ovrOn: seqOvrOn, laneEn: laneEn};
  assign pixWord = packPixel(pixR, pixG, pixB, hsync, vsync, de);

  lvds_ser_ctrl i_ctrl (
    .clk(clk), .rst(rst), .cfgIn(cfgIn), .cfgCap(cfgCap),
    .cfgOut(cfgOut), .stb(stb), .pixReq(pixReq)
  );

  lvds_ser_datapath #(.CLK_PATTERN(CLK_PATTERN)) i_dp (
    .clk(clk), .rst(rst), .stb(stb), .cfgCap(cfgCap), .cfgOut(cfgOut),
    .pixWord(pixWord), .laneBit(laneBit), .laneLowPwr(laneLowPwr),
    .clkLane(clkLane)
  );
endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker
  import lvds_ser_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 pixReq,
  input logic [NUM_LANES-1:0] laneBit,
  input logic [NUM_LANES-1:0] laneLowPwr,
  input logic                 clkLane,
  input cfg_t                 cfgOut,
  input strobe_t              stb
);
  a_r6_idle_when_low: assert property (@(posedge clk) disable iff (rst)
    (laneBit & laneLowPwr) == '0);

  a_r2_no_back_to_back_req: assert property (@(posedge clk) disable iff (rst)
    pixReq |=> !pixReq);

  a_r9_clock_high_at_word_start: assert property (@(posedge clk) disable iff (rst)
    (stb.slot == '0 && cfgOut.portEn) |-> clkLane);

  a_r10_cfg_held_in_frame: assert property (@(posedge clk) disable iff (rst)
    !stb.loadWord |=> $stable(cfgOut));

  a_r8_override_off: assert property (@(posedge clk) disable iff (rst)
    (cfgOut.ovrEn && !cfgOut.ovrOn) |-> (&laneLowPwr));

  a_r7_port_off: assert property (@(posedge clk) disable iff (rst)
    !cfgOut.portEn |-> ((&laneLowPwr) && !clkLane));
endmodule

bind lvds_panel_ser lvds_ser_checker i_chk (
  .clk(clk), .rst(rst), .pixReq(pixReq), .laneBit(laneBit),
  .laneLowPwr(laneLowPwr), .clkLane(clkLane), .cfgOut(cfgOut), .stb(stb)
);

// File: tb/test_lvds_panel_ser.sv
module test_lvds_panel_ser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pixR = '0, pixG = '0, pixB = '0;
  logic hsync = 0, vsync = 0, de = 0;
  logic depth8 = 0, dual = 0, portEn = 0, seqOvrEn = 0, seqOvrOn = 0;
  logic [7:0] laneEn = '0;
  logic pixReq, clkLane;
  logic [7:0] laneBit, laneLowPwr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  lvds_panel_ser i_lvds_panel_ser (
    .clk(clk), .rst(rst), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .hsync(hsync), .vsync(vsync), .de(de), .depth8(depth8), .dual(dual),
    .portEn(portEn), .laneEn(laneEn), .seqOvrEn(seqOvrEn),
    .seqOvrOn(seqOvrOn), .pixReq(pixReq), .laneBit(laneBit),
    .clkLane(clkLane), .laneLowPwr(laneLowPwr)
  );

  // model configuration record: {port, dual, d8, ovE, ovO, en[7:0]}
  typedef struct {
    bit port; bit dl; bit d8; bit ovE; bit ovO; bit [7:0] en;
  } mcfg_t;

  mcfg_t mCap, mOut;
  int mSlot;
  bit [27:0] mHold;
  bit [27:0] mWord [2];

  function automatic bit [27:0] bpack(bit [7:0] r, bit [7:0] g, bit [7:0] b,
                                      bit h, bit v, bit d);
    bit [27:0] w;
    w = '0;
    w[27:22] = r[7:2]; w[21:16] = g[7:2]; w[15:10] = b[7:2];
    w[9] = h; w[8] = v; w[7] = d;
    w[6:5] = r[1:0]; w[4:3] = g[1:0]; w[2:1] = b[1:0];
    return w;
  endfunction

  task automatic modelReset();
    mCap = '{0, 0, 0, 0, 0, 8'h00};
    mOut = mCap;
    mSlot = 0;
    mHold = '0;
    mWord[0] = '0;
    mWord[1] = '0;
  endtask

  task automatic modelStep();
    bit [27:0] pk;
    pk = bpack(pixR, pixG, pixB, hsync, vsync, de);
    if (mSlot == 3 && mCap.dl) mHold = pk;
    if (mSlot == 6) begin
      mWord[0] = mCap.dl ? mHold : pk;
      mWord[1] = mCap.dl ? pk : 28'h0;
      mOut = mCap;
      mCap = '{portEn, dual, depth8, seqOvrEn, seqOvrOn, laneEn};
    end
    mSlot = (mSlot + 1) % 7;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    bit [7:0] expBit, expLow;
    bit expReq, expClk;
    bit [6:0] pat;
    pat = 7'b1100011;
    for (int i = 0; i < 8; i++) begin
      int ch, k;
      bit used, pw;
      ch = i / 4; k = i % 4;
      used = (k < 3 || mOut.d8) && (ch == 0 || mOut.dl);
      pw = mOut.port && used && (mOut.ovE ? mOut.ovO : mOut.en[i]);
      expLow[i] = !pw;
      expBit[i] = pw ? mWord[ch][27 - 7*k - mSlot] : 1'b0;
    end
    expReq = (mSlot == 6) || (mSlot == 3 && mCap.dl);
    expClk = mOut.port && pat[6 - mSlot];
    chk(tag, "laneBit", 32'(laneBit), 32'(expBit));
    chk(tag, "laneLowPwr", 32'(laneLowPwr), 32'(expLow));
    chk(mCap.dl ? "R3" : "R2", "pixReq", 32'(pixReq), 32'(expReq));
    chk(tag == "R1" ? "R1" : "R9", "clkLane", 32'(clkLane), 32'(expClk));
  endtask

  task automatic setCfg(bit p, bit dl, bit d8, bit oe, bit oo, bit [7:0] en);
    portEn = p; dual = dl; depth8 = d8; seqOvrEn = oe; seqOvrOn = oo; laneEn = en;
  endtask

  task automatic runCycles(int n, string tag, bit churn);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cyc++;
      compareAll(tag);
      pixR = 8'(cyc * 37 + 5);
      pixG = 8'(cyc * 91 + 17);
      pixB = 8'(cyc * 13 + 200);
      {hsync, vsync, de} = 3'(cyc * 5);
      if (churn && (c % 3 == 1))
        setCfg(1'b1, 1'(c / 3), 1'(c / 6), 1'(c / 12), 1'(c / 9), 8'(c * 29 + 3));
      modelStep();
    end
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelReset();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cyc++;
      compareAll("R1");  // R1 reset state
    end
    rst = 1'b0;
    setCfg(1, 0, 0, 0, 0, 8'hFF);
    modelStep();
    runCycles(35, "R4", 0);               // R2 R4 single, 6-bit
    setCfg(1, 0, 1, 0, 0, 8'hFF);
    runCycles(35, "R5", 0);               // R5 single, 8-bit
    setCfg(1, 1, 0, 0, 0, 8'hFF);
    runCycles(35, "R3", 0);               // R3 dual, 6-bit
    setCfg(1, 1, 1, 0, 0, 8'hFF);
    runCycles(35, "R4", 0);               // R4 dual, 8-bit
    setCfg(1, 1, 1, 0, 0, 8'b1010_0110);
    runCycles(35, "R6", 0);               // R6 sparse mask
    setCfg(1, 1, 1, 1, 0, 8'hFF);
    runCycles(28, "R8", 0);               // R8 override off beats mask
    setCfg(1, 1, 1, 1, 1, 8'h00);
    runCycles(28, "R8", 0);               // R8 override on beats mask
    setCfg(0, 1, 1, 0, 0, 8'hFF);
    runCycles(28, "R7", 0);               // R7 port disabled
    setCfg(1, 0, 1, 0, 0, 8'hFF);
    runCycles(14, "R9", 0);               // R9 clock lane pattern
    runCycles(84, "R10", 1);              // R10 mid-frame changes
    setCfg(1, 1, 0, 0, 0, 8'hFF);
    runCycles(21, "R10", 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule